// File: doc/BRIEF.md
# DMA Peripheral Request Arbiter

This block sits between up to sixteen peripherals and a single DMA channel engine. Each peripheral drives three request lines: burst, single and last. Each peripheral receives two response lines: an acknowledge and a one-cycle transfer-complete pulse. Every channel carries a 3-bit flow code, a source and a destination peripheral number, an enable and a beat count. The flow code picks the direction of the transfer and the side that decides when it ends, either the DMA count or the peripheral's last request. It also picks which peripheral paces the channel.

When the engine is free, the arbiter chooses the lowest-numbered enabled channel that is ready. It hands that channel to the engine with a burst flag and waits for the engine's beat-done strobe. It then acknowledges the pacing peripheral with a four-phase handshake. On the final beat it pulses transfer-complete and marks the channel done. Memory-to-memory channels need no peripheral and run beat after beat until their count is used up.

Top module: `dma_parb`

## Requirements
- R1: After reset, every acknowledge, transfer-complete, channel-done and engine-valid output is low.
- R2: Flow codes are 0 mem-to-mem (DMA ends), 1 mem-to-periph (DMA), 2 periph-to-mem (DMA), 3 periph-to-periph (DMA), 4 periph-to-periph (destination ends), 5 mem-to-periph (peripheral ends), 6 periph-to-mem (peripheral ends) and 7 periph-to-periph (source ends). The pacing peripheral is the destination for codes 1, 4 and 5 and the source for codes 2, 3, 6 and 7. A peripheral counts as requesting when any of its burst, single or last lines is high.
- R3: A request from a peripheral that is not the pacer of an enabled, unfinished channel never produces an engine grant or an acknowledge.
- R4: A code-0 channel is granted without any request line and with the burst flag set, and it never drives an acknowledge or a transfer-complete.
- R5: Among ready channels, the lowest-numbered one is granted. The choice is made again before every beat.
- R6: While the engine valid output is high, its channel number and burst flag stay stable until beat-done. The burst flag equals the pacer's burst line at the grant. Valid is low in the cycle after beat-done is taken.
- R7: The acknowledge to the pacer rises in the cycle after beat-done. It stays high while any request line of that peripheral is high, and it falls one cycle after all of them are seen low.
- R8: For codes 0 to 3, the beat whose number equals the programmed count is the final beat. A count of zero acts as one.
- R9: For codes 4 to 7, the final beat is the one granted while the pacer's last line is high, and the count is ignored.
- R10: On a final beat, transfer-complete pulses for exactly one cycle on the pacer's line, in the same cycle the acknowledge rises.
- R11: Channel-done is high from the cycle after the final beat until the enable is lowered. A done channel is not granted again. Raising the enable again reloads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| breq_i | input | NUM_PERIPH | Burst request per peripheral |
| sreq_i | input | NUM_PERIPH | Single request per peripheral |
| lreq_i | input | NUM_PERIPH | Last-transfer request per peripheral |
| ack_o | output | NUM_PERIPH | Request accepted, four-phase |
| done_o | output | NUM_PERIPH | Transfer-complete pulse |
| chan_en_i | input | NUM_CHAN | Channel enable |
| chan_src_i | input | NUM_CHAN*PERIPH_W | Source peripheral number per channel |
| chan_dst_i | input | NUM_CHAN*PERIPH_W | Destination peripheral number per channel |
| chan_flow_i | input | NUM_CHAN*3 | Flow code per channel |
| chan_count_i | input | NUM_CHAN*CNT_W | Beat count per channel |
| chan_done_o | output | NUM_CHAN | Channel has finished its transfer |
| eng_valid_o | output | 1 | Beat handed to the engine |
| eng_chan_o | output | CHAN_W | Channel of the current beat |
| eng_burst_o | output | 1 | Current beat is a burst |
| eng_done_i | input | 1 | Engine finished the current beat |

## Verification
A wrong pacer choice or a stale request capture shows up at once: the acknowledge appears on the wrong peripheral line in the cycle after beat-done, or the burst flag is wrong while valid is high. A wrong beat counter or last-request latch stays hidden until the end of the channel. It then shows as a transfer-complete pulse and channel-done one beat early or late, or as grants that keep coming after done. The bench sweeps all eight flow codes and always holds a request on the non-pacing peripheral, so a swapped source and destination is caught by the acknowledges. The priority order is checked by the sequence of channel numbers given to the engine.

// File: rtl/dma_parb_pkg.sv
package dma_parb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_HOLD = 2'd2
   } arb_state_e;

   // flow code 0: memory to memory, no peripheral involved
   function automatic logic flow_is_m2m(input logic [2:0] f);
      return f == 3'd0;
   endfunction

   // destination peripheral paces codes 1, 4 and 5
   function automatic logic flow_pacer_dst(input logic [2:0] f);
      return (f == 3'd1) || (f == 3'd4) || (f == 3'd5);
   endfunction

   // codes 4..7 end on the peripheral's last request
   function automatic logic flow_periph_ends(input logic [2:0] f);
      return f[2];
   endfunction

endpackage

// File: rtl/dma_parb_decode.sv
module dma_parb_decode
   import dma_parb_pkg::*;
#(
   parameter int NUM_PERIPH = 16,
   parameter int NUM_CHAN   = 4,
   parameter int PERIPH_W   = 4
) (
   input  logic [NUM_PERIPH-1:0]        pend_i,
   input  logic [NUM_CHAN*PERIPH_W-1:0] src_i,
   input  logic [NUM_CHAN*PERIPH_W-1:0] dst_i,
   input  logic [NUM_CHAN*3-1:0]        flow_i,
   output logic [NUM_CHAN-1:0]          ready_o,
   output logic [NUM_CHAN*PERIPH_W-1:0] pacer_o
);

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      logic [2:0]          fl;
      logic [PERIPH_W-1:0] pacer;
      assign fl    = flow_i[c*3 +: 3];
      assign pacer = flow_pacer_dst(fl) ? dst_i[c*PERIPH_W +: PERIPH_W]
                                        : src_i[c*PERIPH_W +: PERIPH_W];
      assign pacer_o[c*PERIPH_W +: PERIPH_W] = pacer;
      assign ready_o[c] = flow_is_m2m(fl) | pend_i[pacer];
   end

endmodule

// File: rtl/dma_parb_pick.sv
module dma_parb_pick #(
   parameter int NUM_CHAN = 4,
   parameter int CHAN_W   = 2
) (
   input  logic [NUM_CHAN-1:0] req_i,
   output logic                valid_o,
   output logic [CHAN_W-1:0]   idx_o
);

   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      for (int i = NUM_CHAN - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            valid_o = 1'b1;
            idx_o   = CHAN_W'(i);
         end
      end
   end

endmodule

// File: rtl/dma_parb_chan_ctx.sv
module dma_parb_chan_ctx #(
   parameter int NUM_CHAN = 4,
   parameter int CNT_W    = 8,
   parameter int CHAN_W   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CHAN-1:0]       en_i,
   input  logic [NUM_CHAN*CNT_W-1:0] count_i,
   input  logic                      beat_done_i,
   input  logic [CHAN_W-1:0]         beat_chan_i,
   input  logic                      beat_final_i,
   output logic [NUM_CHAN-1:0]       live_o,
   output logic [NUM_CHAN-1:0]       fin_o,
   output logic [NUM_CHAN-1:0]       one_left_o
);

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      logic             en_q;
      logic             fin_q;
      logic [CNT_W-1:0] rem_q;
      logic [CNT_W-1:0] load_val;
      logic             hit;

      assign load_val = (count_i[c*CNT_W +: CNT_W] == '0) ? CNT_W'(1)
                                                        : count_i[c*CNT_W +: CNT_W];
      assign hit      = beat_done_i && (beat_chan_i == CHAN_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q  <= 1'b0;
            fin_q <= 1'b0;
            rem_q <= '0;
         end else begin
            en_q <= en_i[c];
            if (en_i[c] && !en_q) begin
               rem_q <= load_val;
               fin_q <= 1'b0;
            end else if (!en_i[c]) begin
               fin_q <= 1'b0;
            end else if (hit) begin
               rem_q <= rem_q - CNT_W'(1);
               if (beat_final_i) fin_q <= 1'b1;
            end
         end
      end

      assign live_o[c]     = en_i[c] & en_q & ~fin_q;
      assign fin_o[c]      = fin_q & en_i[c];
      assign one_left_o[c] = (rem_q == CNT_W'(1));

      // R11
      beat_on_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> (en_q && !fin_q));
   end

endmodule

// File: rtl/dma_parb.sv
module dma_parb
   import dma_parb_pkg::*;
#(
   parameter int NUM_PERIPH = 16,
   parameter int NUM_CHAN   = 4,
   parameter int CNT_W      = 8,
   localparam int PERIPH_W  = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1,
   localparam int CHAN_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PERIPH-1:0]        breq_i,
   input  logic [NUM_PERIPH-1:0]        sreq_i,
   input  logic [NUM_PERIPH-1:0]        lreq_i,
   output logic [NUM_PERIPH-1:0]        ack_o,
   output logic [NUM_PERIPH-1:0]        done_o,
   input  logic [NUM_CHAN-1:0]          chan_en_i,
   input  logic [NUM_CHAN*PERIPH_W-1:0] chan_src_i,
   input  logic [NUM_CHAN*PERIPH_W-1:0] chan_dst_i,
   input  logic [NUM_CHAN*3-1:0]        chan_flow_i,
   input  logic [NUM_CHAN*CNT_W-1:0]    chan_count_i,
   output logic [NUM_CHAN-1:0]          chan_done_o,
   output logic                         eng_valid_o,
   output logic [CHAN_W-1:0]            eng_chan_o,
   output logic                         eng_burst_o,
   input  logic                         eng_done_i
);

   if (NUM_PERIPH < 2 || NUM_PERIPH > 16) begin : g_np_bad
      $error("dma_parb: NUM_PERIPH must lie in 2..16");
   end
   if (NUM_CHAN < 1) begin : g_nc_bad
      $error("dma_parb: NUM_CHAN must be at least 1");
   end
   if (CNT_W < 1) begin : g_cw_bad
      $error("dma_parb: CNT_W must be at least 1");
   end

   logic [NUM_PERIPH-1:0]        pend;
   logic [NUM_CHAN-1:0]          ready_raw;
   logic [NUM_CHAN*PERIPH_W-1:0] pacer_flat;
   logic [NUM_CHAN-1:0]          live;
   logic [NUM_CHAN-1:0]          one_left;
   logic [NUM_CHAN-1:0]          cand;
   logic                         pick_v;
   logic [CHAN_W-1:0]            pick_idx;

   arb_state_e            state_q;
   logic [CHAN_W-1:0]     cur_ch_q;
   logic [PERIPH_W-1:0]   cur_pacer_q;
   logic                  cur_m2m_q;
   logic                  cur_perend_q;
   logic                  cur_burst_q;
   logic                  cur_last_q;
   logic [NUM_PERIPH-1:0] ack_q;
   logic [NUM_PERIPH-1:0] done_q;
   logic                  beat_done;
   logic                  beat_final;
   logic [2:0]            pick_flow;
   logic [PERIPH_W-1:0]   pick_pacer;

   assign pend = breq_i | sreq_i | lreq_i;

   dma_parb_decode #(
      .NUM_PERIPH(NUM_PERIPH), .NUM_CHAN(NUM_CHAN), .PERIPH_W(PERIPH_W)
   ) decode_i (
      .pend_i (pend),
      .src_i  (chan_src_i),
      .dst_i  (chan_dst_i),
      .flow_i (chan_flow_i),
      .ready_o(ready_raw),
      .pacer_o(pacer_flat)
   );

   assign beat_done  = (state_q == ST_BUSY) && eng_done_i;
   assign beat_final = cur_perend_q ? cur_last_q : one_left[cur_ch_q];

   dma_parb_chan_ctx #(
      .NUM_CHAN(NUM_CHAN), .CNT_W(CNT_W), .CHAN_W(CHAN_W)
   ) ctx_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (chan_en_i),
      .count_i     (chan_count_i),
      .beat_done_i (beat_done),
      .beat_chan_i (cur_ch_q),
      .beat_final_i(beat_final),
      .live_o      (live),
      .fin_o       (chan_done_o),
      .one_left_o  (one_left)
   );

   assign cand = ready_raw & live;

   dma_parb_pick #(
      .NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)
   ) pick_i (
      .req_i  (cand),
      .valid_o(pick_v),
      .idx_o  (pick_idx)
   );

   assign pick_flow  = chan_flow_i[pick_idx*3 +: 3];
   assign pick_pacer = pacer_flat[pick_idx*PERIPH_W +: PERIPH_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cur_ch_q     <= '0;
         cur_pacer_q  <= '0;
         cur_m2m_q    <= 1'b0;
         cur_perend_q <= 1'b0;
         cur_burst_q  <= 1'b0;
         cur_last_q   <= 1'b0;
         ack_q        <= '0;
         done_q       <= '0;
      end else begin
         done_q <= '0;
         case (state_q)
            ST_IDLE: begin
               if (pick_v) begin
                  state_q      <= ST_BUSY;
                  cur_ch_q     <= pick_idx;
                  cur_pacer_q  <= pick_pacer;
                  cur_m2m_q    <= flow_is_m2m(pick_flow);
                  cur_perend_q <= flow_periph_ends(pick_flow);
                  cur_burst_q  <= flow_is_m2m(pick_flow) | breq_i[pick_pacer];
                  cur_last_q   <= lreq_i[pick_pacer];
               end
            end
            ST_BUSY: begin
               if (eng_done_i) begin
                  if (cur_m2m_q) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q              <= ST_HOLD;
                     ack_q[cur_pacer_q]   <= 1'b1;
                     done_q[cur_pacer_q]  <= beat_final;
                  end
               end
            end
            ST_HOLD: begin
               if (!pend[cur_pacer_q]) begin
                  ack_q   <= '0;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ack_o       = ack_q;
   assign done_o      = done_q;
   assign eng_valid_o = (state_q == ST_BUSY);
   assign eng_chan_o  = cur_ch_q;
   assign eng_burst_o = cur_burst_q;

   // R7
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o));

   // R7
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(ack_o & pend) |=> (ack_o == $past(ack_o)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |done_o |=> !(|done_o));

   // R10
   done_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o & ~ack_o) == '0);

   // R6
   eng_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid_o && !eng_done_i) |=> (eng_valid_o && $stable(eng_chan_o)
                                        && $stable(eng_burst_o)));

   // R6
   eng_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid_o && eng_done_i) |=> !eng_valid_o);

endmodule

// File: tb/dma_parb_tb.sv
module dma_parb_tb_top;

   localparam int NP = 16;
   localparam int NC = 4;
   localparam int CW = 8;
   localparam int PW = 4;
   localparam int HW = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     breq = '0, sreq = '0, lreq = '0;
   logic [NP-1:0]     ack, done;
   logic [NC-1:0]     en = '0;
   logic [NC*PW-1:0]  src = '0, dst = '0;
   logic [NC*3-1:0]   flow = '0;
   logic [NC*CW-1:0]  cnt = '0;
   logic [NC-1:0]     cdone;
   logic              evalid, eburst;
   logic [HW-1:0]     echan;
   logic              edone = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   dma_parb #(.NUM_PERIPH(NP), .NUM_CHAN(NC), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .breq_i(breq), .sreq_i(sreq), .lreq_i(lreq),
      .ack_o(ack), .done_o(done),
      .chan_en_i(en), .chan_src_i(src), .chan_dst_i(dst),
      .chan_flow_i(flow), .chan_count_i(cnt), .chan_done_o(cdone),
      .eng_valid_o(evalid), .eng_chan_o(echan), .eng_burst_o(eburst),
      .eng_done_i(edone)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL R6 watchdog actual=%0d expected<150000 cycles", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_valid(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (evalid) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   task automatic no_grant(input int cycles, input string req);
      int hits = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (evalid || ack != '0) hits++;
      end
      chk(hits == 0, req, hits, 0);
   endtask

   // one peripheral-paced beat on pacer p
   task automatic pbeat(input int p, input bit burst, input bit last,
                        input int exp_ch, input bit exp_final, input string req);
      bit seen;
      @(negedge clk);
      breq[p] = burst; sreq[p] = !burst; lreq[p] = last;
      wait_valid(seen);
      chk(seen, "R2 grant for pacer", seen, 1);
      chk(echan == HW'(exp_ch), "R5 engine channel", echan, exp_ch);
      chk(eburst == burst, "R6 burst flag", eburst, burst);
      chk(ack[p] == 1'b0, "R7 no ack before beat done", ack[p], 0);
      edone = 1'b1;
      @(negedge clk);
      edone = 1'b0;
      chk(!evalid, "R6 valid released", evalid, 0);
      chk(ack[p] == 1'b1, "R7 ack rises", ack[p], 1);
      chk(done[p] == exp_final, req, done[p], exp_final);
      @(negedge clk);
      chk(done[p] == 1'b0, "R10 done one cycle", done[p], 0);
      chk(ack[p] == 1'b1, "R7 ack held", ack[p], 1);
      breq[p] = 1'b0; sreq[p] = 1'b0; lreq[p] = 1'b0;
      @(negedge clk);
      chk(ack[p] == 1'b0, "R7 ack falls", ack[p], 0);
   endtask

   task automatic mbeat(input int exp_ch);
      bit seen;
      wait_valid(seen);
      chk(seen, "R4 m2m grant without request", seen, 1);
      chk(echan == HW'(exp_ch), "R5 m2m channel order", echan, exp_ch);
      chk(eburst == 1'b1, "R4 m2m burst", eburst, 1);
      edone = 1'b1;
      @(negedge clk);
      edone = 1'b0;
      chk(ack == '0 && done == '0, "R4 m2m no response", int'(ack | done), 0);
   endtask

   initial begin
      int pacer, other;
      bit perend;
      repeat (3) @(negedge clk);
      chk(ack == '0 && done == '0, "R1 responses at reset", int'(ack | done), 0);
      chk(!evalid && cdone == '0, "R1 engine and done at reset", int'(evalid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: no channel enabled, every line high
      breq = '1; sreq = '1; lreq = '1;
      no_grant(20, "R3 unmapped requests ignored");
      breq = '0; sreq = '0; lreq = '0;

      // sweep every flow code on channel 1, src 3, dst 9
      for (int f = 0; f < 8; f++) begin
         perend = (f >= 4);
         pacer  = (f == 1 || f == 4 || f == 5) ? 9 : 3;
         other  = (pacer == 9) ? 3 : 9;
         src[1*PW +: PW] = 4'd3;
         dst[1*PW +: PW] = 4'd9;
         flow[1*3 +: 3]  = 3'(f);
         cnt[1*CW +: CW] = perend ? 8'd1 : 8'd3;
         @(negedge clk);
         en[1] = 1'b1;
         if (f == 0) begin
            sreq[3] = 1'b1; sreq[9] = 1'b1;
            for (int b = 0; b < 3; b++) begin
               mbeat(1);
               chk(cdone[1] == (b == 2), "R8 m2m final at count", cdone[1], b == 2);
            end
            sreq[3] = 1'b0; sreq[9] = 1'b0;
         end else begin
            sreq[other] = 1'b1;
            for (int b = 0; b < 3; b++) begin
               pbeat(pacer, b[0], perend && b == 2, 1, b == 2,
                     perend ? "R9 final on last request" : "R8 final at count");
               chk(cdone[1] == (b == 2), "R11 channel done timing", cdone[1], b == 2);
               chk(ack[other] == 1'b0, "R2 non-pacer not acked", ack[other], 0);
            end
            sreq[other] = 1'b0;
         end
         // R11: finished channel never granted again
         @(negedge clk);
         sreq[pacer] = 1'b1;
         no_grant(10, "R11 finished channel idle");
         sreq[pacer] = 1'b0;
         en[1] = 1'b0;
         @(negedge clk);
         chk(cdone[1] == 1'b0, "R11 done clears on disable", cdone[1], 0);
      end

      // R5: two m2m channels at once, count 2 each
      flow = '0;
      cnt[0*CW +: CW] = 8'd2;
      cnt[2*CW +: CW] = 8'd2;
      @(negedge clk);
      en = 4'b0101;
      mbeat(0); mbeat(0); mbeat(2); mbeat(2);
      chk(cdone == 4'b0101, "R8 both channels done", cdone, 4'b0101);
      no_grant(8, "R11 no grant after done");
      en = '0;
      @(negedge clk);

      // R5: peripheral channels, ch3 P2M from 2, ch1 M2P to 11
      flow[3*3 +: 3] = 3'd2; src[3*PW +: PW] = 4'd2; cnt[3*CW +: CW] = 8'd1;
      flow[1*3 +: 3] = 3'd1; dst[1*PW +: PW] = 4'd11; cnt[1*CW +: CW] = 8'd1;
      @(negedge clk);
      sreq[2] = 1'b1;
      en = 4'b1010;
      pbeat(11, 1'b1, 1'b0, 1, 1'b1, "R10 done on ch1 final");
      pbeat(2, 1'b0, 1'b0, 3, 1'b1, "R10 done on ch3 final");
      chk(cdone == 4'b1010, "R11 both done", cdone, 4'b1010);
      en = '0;
      flow = '0;
      @(negedge clk);

      // R8: count zero acts as one
      cnt[3*CW +: CW] = 8'd0;
      @(negedge clk);
      en[3] = 1'b1;
      mbeat(3);
      chk(cdone[3] == 1'b1, "R8 zero count one beat", cdone[3], 1);
      no_grant(8, "R8 zero count stops");
      en[3] = 1'b0;
      @(negedge clk);

      // R11: re-enable reloads count
      cnt[3*CW +: CW] = 8'd2;
      @(negedge clk);
      en[3] = 1'b1;
      mbeat(3);
      chk(cdone[3] == 1'b0, "R11 reload not done after one", cdone[3], 0);
      mbeat(3);
      chk(cdone[3] == 1'b1, "R11 reload done after two", cdone[3], 1);
      en[3] = 1'b0;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule